// File: doc/BRIEF.md
# One-Address Accumulator Processor with Index Register

This block is a small multi-cycle processor. Its visible state is a 16-bit accumulator A, a 12-bit index register X, a 12-bit program counter and a zero/equal flag Z. Every instruction is one 16-bit word. The word holds a 4-bit opcode and one 12-bit field M. M is either a constant or a memory address. The opcode alone selects how M is used: as an immediate value, as a direct address, or as a base that is added to X. Code and data share one internal word memory.

A second memory port is brought out to the surrounding logic. The testbench uses it to place programs and data while the core is held in reset, and to read results back once the core has halted. Typical code clears X, then steps through an array with an indexed add, an increment of X, a compare of X against a count in memory, and a branch-if-not-equal back to the loop head.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, A, X, Z and PC are cleared and `halted` is 0. After reset is released, execution starts at word 0 with A equal to 0.
- R2: Bits [15:12] of an instruction hold the opcode and bits [11:0] hold M. The opcodes are: 0 HALT, 1 LDI, 2 LD, 3 LDX, 4 ADDI, 5 ADD, 6 ADDX, 7 SUB, 8 SUBX, 9 ANDI, A ORI, B ST, C STX, D XOP, E CMPX, F BNE.
- R3: The immediate forms use M, zero-extended to 16 bits, as the operand. LDI sets A = M, ADDI sets A = A + M, ANDI sets A = A & M, and ORI sets A = A | M.
- R4: The direct forms LD, ADD and SUB read their operand from mem[M]. Addition and subtraction wrap modulo 2^16.
- R5: The indexed forms LDX, ADDX, SUBX and STX use the address (M + X) mod 4096.
- R6: ST writes A to mem[M] and STX writes A to mem[(M + X) mod 4096]. A store leaves A and Z unchanged.
- R7: XOP with M[0] = 0 clears X. XOP with M[0] = 1 increments X modulo 4096.
- R8: CMPX sets Z to 1 when the zero-extended X equals mem[M], and to 0 otherwise. Every load or ALU instruction sets Z to 1 when its result is zero. Stores, XOP and BNE leave Z unchanged.
- R9: BNE loads PC with M when Z is 0. When Z is 1 it falls through to PC + 1. Every other instruction advances PC by one.
- R10: HALT sets `halted`. From then on no memory is written, and `halted` stays 1 until the next reset.
- R11: The host port writes `host_wdata` to word `host_addr` when `host_we` is 1. It returns the word at `host_addr` on `host_rdata` one clock later. A memory address selects the word at (address mod MEM_DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host-port write strobe |
| host_addr | input | 12 | Host-port word address |
| host_wdata | input | 16 | Host-port write data |
| host_rdata | output | 16 | Host-port read data, one cycle after the address |
| halted | output | 1 | High once a HALT has executed |

## Verification
On every cycle, the assertions check the control-flow and register rules:
- the PC either steps by one or, on a taken branch, jumps to M;
- X clears or increments exactly as XOP asks;
- a store leaves A and Z alone;
- at most one state-changing event fires in a cycle;
- `halted` is sticky and blocks writes.

Only the bench's programs can show that the arithmetic and logic results are correct, that indexed addresses wrap at 4096, that compares and ALU results drive the branch decision, and that a whole array-summing loop ends with the correct total and the correct final X.

// File: rtl/acc_pkg.sv
package acc_pkg;
  parameter int WORD_W = 16;
  parameter int ADDR_W = 12;
  parameter int OPC_W  = 4;
  localparam int PAD_W = WORD_W - ADDR_W;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT = 4'h0, OP_LDI  = 4'h1, OP_LD   = 4'h2, OP_LDX  = 4'h3,
    OP_ADDI = 4'h4, OP_ADD  = 4'h5, OP_ADDX = 4'h6, OP_SUB  = 4'h7,
    OP_SUBX = 4'h8, OP_ANDI = 4'h9, OP_ORI  = 4'hA, OP_ST   = 4'hB,
    OP_STX  = 4'hC, OP_XOP  = 4'hD, OP_CMPX = 4'hE, OP_BNE  = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {K_PASS, K_ADD, K_SUB, K_AND, K_OR} alu_kind_e;

  typedef enum logic [2:0] {
    C_HALT, C_IMM, C_MEMRD, C_STORE, C_XOP, C_CMPX, C_BNE
  } iclass_e;

  typedef enum logic [1:0] {S_FETCH, S_DEC, S_EXEC, S_HALT} cpu_state_e;

  function automatic iclass_e op_class(opcode_e op);
    case (op)
      OP_HALT:                        return C_HALT;
      OP_LDI, OP_ADDI, OP_ANDI, OP_ORI: return C_IMM;
      OP_ST, OP_STX:                  return C_STORE;
      OP_XOP:                         return C_XOP;
      OP_CMPX:                        return C_CMPX;
      OP_BNE:                         return C_BNE;
      default:                        return C_MEMRD;
    endcase
  endfunction

  function automatic alu_kind_e op_kind(opcode_e op);
    case (op)
      OP_ADDI, OP_ADD, OP_ADDX: return K_ADD;
      OP_SUB, OP_SUBX:          return K_SUB;
      OP_ANDI:                  return K_AND;
      OP_ORI:                   return K_OR;
      default:                  return K_PASS;
    endcase
  endfunction

  function automatic logic op_indexed(opcode_e op);
    return (op == OP_LDX) || (op == OP_ADDX) || (op == OP_SUBX) || (op == OP_STX);
  endfunction

  function automatic logic [WORD_W-1:0] alu_apply(alu_kind_e k,
                                                  logic [WORD_W-1:0] a,
                                                  logic [WORD_W-1:0] b);
    case (k)
      K_ADD:   return a + b;
      K_SUB:   return a - b;
      K_AND:   return a & b;
      K_OR:    return a | b;
      default: return b;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] eff_addr(logic [ADDR_W-1:0] m,
                                                 logic [ADDR_W-1:0] x,
                                                 logic idx);
    return idx ? (m + x) : m;
  endfunction
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
(
  input  alu_kind_e         kind,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic [WORD_W-1:0] res,
  output logic              res_zero
);
  always_comb begin
    res      = alu_apply(kind, opa, opb);
    res_zero = (res == '0);
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] cells [DEPTH];
  logic [IDX_W-1:0]  a_slot, b_slot;

  function automatic logic [IDX_W-1:0] slot_of(logic [ADDR_W-1:0] adr);
    return IDX_W'(32'(adr) % 32'(DEPTH));
  endfunction

  always_comb begin
    a_slot = slot_of(a_addr);
    b_slot = slot_of(b_addr);
  end

  // The core port wins when both ports write one word in the same cycle.
  always_ff @(posedge clk) begin
    if (a_we) cells[a_slot] <= a_wdata;
    if (b_we && !(a_we && (a_slot == b_slot))) cells[b_slot] <= b_wdata;
    a_rdata <= cells[a_slot];
    b_rdata <= cells[b_slot];
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted
);
  cpu_state_e        st, st_nx;
  logic [ADDR_W-1:0] pc, x_reg, ir_m, m_now, ea;
  logic [WORD_W-1:0] acc, alu_b, alu_y;
  logic              zf, alu_zero;
  opcode_e           ir_op, opc_now;
  iclass_e           cls;
  alu_kind_e         kind;
  logic              in_dec, in_exec;

  // Named internal events, one per kind of state change.
  logic ev_alu_wr, ev_cmp, ev_store, ev_clrx, ev_incx, ev_taken, ev_done, ev_halt;

  always_comb begin
    in_dec  = (st == S_DEC);
    in_exec = (st == S_EXEC);
    opc_now = in_dec ? opcode_e'(mem_rdata[WORD_W-1 -: OPC_W]) : ir_op;
    m_now   = in_dec ? mem_rdata[ADDR_W-1:0] : ir_m;
    cls     = op_class(opc_now);
    kind    = op_kind(opc_now);
    ea      = eff_addr(m_now, x_reg, op_indexed(opc_now));
    alu_b   = (cls == C_IMM) ? {{PAD_W{1'b0}}, m_now} : mem_rdata;
  end

  acc_alu u_alu (
    .kind    (kind),
    .opa     (acc),
    .opb     (alu_b),
    .res     (alu_y),
    .res_zero(alu_zero)
  );

  always_comb begin
    ev_alu_wr = (in_dec && cls == C_IMM) || (in_exec && cls == C_MEMRD);
    ev_cmp    = in_exec && (cls == C_CMPX);
    ev_store  = in_dec && (cls == C_STORE);
    ev_clrx   = in_dec && (cls == C_XOP) && !m_now[0];
    ev_incx   = in_dec && (cls == C_XOP) && m_now[0];
    ev_taken  = in_dec && (cls == C_BNE) && !zf;
    ev_halt   = in_dec && (cls == C_HALT);
    ev_done   = in_exec ||
                (in_dec && (cls == C_IMM || cls == C_STORE || cls == C_XOP || cls == C_BNE));
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_FETCH: st_nx = S_DEC;
      S_DEC:   st_nx = ev_halt ? S_HALT : (ev_done ? S_FETCH : S_EXEC);
      S_EXEC:  st_nx = S_FETCH;
      default: st_nx = S_HALT;
    endcase
  end

  always_comb begin
    mem_addr  = (st == S_FETCH) ? pc : ea;
    mem_we    = ev_store;
    mem_wdata = acc;
    halted    = (st == S_HALT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_FETCH;
      pc    <= '0;
      x_reg <= '0;
      acc   <= '0;
      zf    <= 1'b0;
      ir_op <= OP_HALT;
      ir_m  <= '0;
    end else begin
      st <= st_nx;
      if (in_dec) begin
        ir_op <= opc_now;
        ir_m  <= m_now;
      end
      if (ev_alu_wr) begin
        acc <= alu_y;
        zf  <= alu_zero;
      end
      if (ev_cmp)  zf <= ({{PAD_W{1'b0}}, x_reg} == mem_rdata);
      if (ev_clrx) x_reg <= '0;
      if (ev_incx) x_reg <= x_reg + 1'b1;
      if (ev_done) pc <= ev_taken ? m_now : pc + 1'b1;
    end
  end

  // R9: the program counter steps by one unless a branch is taken.
  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !ev_taken) |=> pc == ADDR_W'($past(pc) + 1'b1));
  p_pc_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_taken |=> pc == $past(m_now));
  // R7: index register maintenance.
  p_x_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clrx |=> x_reg == '0);
  p_x_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incx |=> x_reg == ADDR_W'($past(x_reg) + 1'b1));
  // R6: a store leaves the accumulator and the flag alone.
  p_store_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (acc == $past(acc)) && (zf == $past(zf)));
  // R8: at most one state-changing event fires in a cycle.
  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_alu_wr, ev_cmp, ev_store, ev_clrx, ev_incx}));
  // R10: halt is sticky and silences memory writes.
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_pkg::*;
#(
  parameter int MEM_DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              halted
);
  logic [ADDR_W-1:0] core_addr;
  logic [WORD_W-1:0] core_wdata, core_rdata;
  logic              core_we;

  acc_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (core_addr),
    .mem_wdata(core_wdata),
    .mem_we   (core_we),
    .mem_rdata(core_rdata),
    .halted   (halted)
  );

  acc_mem #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W),
    .DEPTH (MEM_DEPTH)
  ) u_mem (
    .clk    (clk),
    .a_addr (core_addr),
    .a_we   (core_we),
    .a_wdata(core_wdata),
    .a_rdata(core_rdata),
    .b_addr (host_addr),
    .b_we   (host_we),
    .b_wdata(host_wdata),
    .b_rdata(host_rdata)
  );

  // R1: no core write can happen while reset is held.
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !core_we);
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        halted;

  int n_checks = 0;
  int n_errs   = 0;

  always #5 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .halted(halted)
  );

  function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] m);
    return {op, m};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
  endtask

  task automatic run_to_halt(string req);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check(req, {15'b0, halted}, 16'h0001);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h080, 16'h1234);
    hwrite(12'h000, ins(4'hB, 12'h080));
    hwrite(12'h001, ins(4'h0, 12'h000));
    check("R1 halted low in reset", {15'b0, halted}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 halted low after reset", {15'b0, halted}, 16'h0000);
    for (int i = 0; i < 50 && !halted; i++) @(negedge clk);
    check("R10 halt reached", {15'b0, halted}, 16'h0001);
    hread(12'h080, v);
    check("R1 accumulator starts at zero", v, 16'h0000);
  endtask

  task automatic t_immediate();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h000, ins(4'h1, 12'h0F0));
    hwrite(12'h001, ins(4'hA, 12'h00F));
    hwrite(12'h002, ins(4'h9, 12'h0FC));
    hwrite(12'h003, ins(4'h4, 12'h010));
    hwrite(12'h004, ins(4'hB, 12'h080));
    hwrite(12'h005, ins(4'h0, 12'h000));
    run_to_halt("R10 immediate program halts");
    hread(12'h080, v);
    check("R3 LDI/ORI/ANDI/ADDI chain", v, 16'h010C);
  endtask

  task automatic t_direct();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h090, 16'hFFFF);
    hwrite(12'h091, 16'h0003);
    hwrite(12'h000, ins(4'h2, 12'h090));
    hwrite(12'h001, ins(4'h5, 12'h091));
    hwrite(12'h002, ins(4'hB, 12'h081));
    hwrite(12'h003, ins(4'h7, 12'h091));
    hwrite(12'h004, ins(4'h7, 12'h091));
    hwrite(12'h005, ins(4'hB, 12'h080));
    hwrite(12'h006, ins(4'h0, 12'h000));
    run_to_halt("R10 direct program halts");
    hread(12'h081, v);
    check("R4 ADD wraps", v, 16'h0002);
    hread(12'h080, v);
    check("R4 SUB wraps below zero", v, 16'hFFFC);
  endtask

  task automatic t_array_loop();
    logic [15:0] v;
    enter_reset();
    for (int i = 0; i < 5; i++) hwrite(12'h0A0 + 12'(i), 16'(i + 1));
    hwrite(12'h09F, 16'd5);
    hwrite(12'h000, ins(4'h1, 12'h000));
    hwrite(12'h001, ins(4'hD, 12'h000));
    hwrite(12'h002, ins(4'h6, 12'h0A0));
    hwrite(12'h003, ins(4'hD, 12'h001));
    hwrite(12'h004, ins(4'hE, 12'h09F));
    hwrite(12'h005, ins(4'hF, 12'h002));
    hwrite(12'h006, ins(4'hB, 12'h080));
    hwrite(12'h007, ins(4'h1, 12'h777));
    hwrite(12'h008, ins(4'hC, 12'h090));
    hwrite(12'h009, ins(4'h0, 12'h000));
    run_to_halt("R10 loop program halts");
    hread(12'h080, v);
    check("R5 R9 indexed sum loop", v, 16'd15);
    hread(12'h095, v);
    check("R7 R8 X ends at count, STX target", v, 16'h0777);
  endtask

  task automatic t_index_wrap();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h000, ins(4'hD, 12'h000));
    hwrite(12'h001, ins(4'hD, 12'h001));
    hwrite(12'h002, ins(4'hD, 12'h001));
    hwrite(12'h003, ins(4'h3, 12'hFFF));
    hwrite(12'h004, ins(4'hB, 12'h080));
    hwrite(12'h005, ins(4'h0, 12'h000));
    run_to_halt("R10 wrap program halts");
    hread(12'h080, v);
    check("R5 M+X wraps at 4096", v, ins(4'hD, 12'h001));
  endtask

  task automatic t_flag_fall_through();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h091, 16'h0005);
    hwrite(12'h000, ins(4'h1, 12'h005));
    hwrite(12'h001, ins(4'h7, 12'h091));
    hwrite(12'h002, ins(4'hB, 12'h081));
    hwrite(12'h003, ins(4'hD, 12'h001));
    hwrite(12'h004, ins(4'hF, 12'h008));
    hwrite(12'h005, ins(4'h1, 12'h111));
    hwrite(12'h006, ins(4'hB, 12'h080));
    hwrite(12'h007, ins(4'h0, 12'h000));
    hwrite(12'h008, ins(4'h1, 12'h222));
    hwrite(12'h009, ins(4'hB, 12'h080));
    hwrite(12'h00A, ins(4'h0, 12'h000));
    run_to_halt("R10 fall-through program halts");
    hread(12'h080, v);
    check("R8 R9 zero result, store and XOP keep Z, BNE falls", v, 16'h0111);
  endtask

  task automatic t_flag_taken();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h000, ins(4'h1, 12'h001));
    hwrite(12'h001, ins(4'hF, 12'h008));
    hwrite(12'h002, ins(4'h1, 12'h111));
    hwrite(12'h003, ins(4'hB, 12'h080));
    hwrite(12'h004, ins(4'h0, 12'h000));
    hwrite(12'h008, ins(4'h1, 12'h222));
    hwrite(12'h009, ins(4'hB, 12'h080));
    hwrite(12'h00A, ins(4'h0, 12'h000));
    run_to_halt("R10 taken program halts");
    hread(12'h080, v);
    check("R9 BNE taken on nonzero", v, 16'h0222);
  endtask

  task automatic t_halt_sticky();
    logic [15:0] v;
    enter_reset();
    hwrite(12'h080, 16'hBEEF);
    hwrite(12'h000, ins(4'h1, 12'h055));
    hwrite(12'h001, ins(4'h0, 12'h000));
    hwrite(12'h002, ins(4'hB, 12'h080));
    run_to_halt("R10 halts");
    repeat (20) @(negedge clk);
    check("R10 halted stays high", {15'b0, halted}, 16'h0001);
    hread(12'h080, v);
    check("R10 no execution after HALT", v, 16'hBEEF);
  endtask

  task automatic t_host_port();
    logic [15:0] v;
    hwrite(12'h070, 16'hA5A5);
    hread(12'h070, v);
    check("R11 host write then read", v, 16'hA5A5);
    hread(12'h170, v);
    check("R11 address folds modulo depth", v, 16'hA5A5);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_immediate();
    t_direct();
    t_array_loop();
    t_index_wrap();
    t_flag_fall_through();
    t_flag_taken();
    t_halt_sticky();
    t_host_port();
    // R2: each program above relies on the opcode values given there.
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule